// File: doc/BRIEF.md
# Lite AXI Slave to Register Bus Bridge

This block sits behind an AXI4-Lite-style slave port and turns each single read or write transaction into exactly one access on a simple synchronous register bus. The register bus carries a strobe, a write flag, an address, write data with byte enables, read data and an acknowledge. The register-bus slave may stretch an access by holding its acknowledge low.

A read address is taken in the same cycle it is offered while the bridge is idle, and it is copied into an internal register. The register-bus access is driven from that register, starting on the next cycle. The read response can never appear in the cycle the address is taken, because some interconnects do not sample a read-valid raised in that cycle. When the register-bus slave acknowledges at once, the response still leaves one cycle after acceptance. Writes follow the same scheme and are accepted only when address and data are offered together. A write with a partial byte-enable mask, such as a 32-bit store to a 64-bit word, reaches the register bus with only those byte lanes enabled.

Top module: `axil_regbus_bridge`

## Requirements
- R1: While idle, `s_arready` is high, and a read address offered with `s_arvalid` is accepted on that clock edge with no wait cycle.
- R2: `s_rvalid` is never high in a cycle in which `s_arvalid` and `s_arready` are both high.
- R3: During a register-bus access, `rb_addr` (and for writes `rb_wdata` and `rb_be`) hold the values accepted from the AXI side, even if the AXI address and data inputs change after acceptance.
- R4: `rb_stb` rises with `rb_we` low in the cycle after read-address acceptance. If `rb_ack` is high in that cycle, `s_rvalid` is high in the same cycle, with `s_rdata` equal to `rb_rdata` and `s_rresp` equal to 2'b00.
- R5: While the register-bus slave withholds `rb_ack` during a read, `s_rvalid` stays low. It rises in the cycle the acknowledge arrives.
- R6: Once `s_rvalid` is high, it and `s_rdata` stay unchanged until `s_rready` is high on a clock edge. After that edge the bridge is idle, with `s_rvalid` low and `s_arready` high.
- R7: While idle with no read pending, `s_awready` and `s_wready` are high together only when `s_awvalid` and `s_wvalid` are both high. The register-bus write (`rb_stb` and `rb_we` high) starts on the next cycle with `rb_be` equal to the accepted `s_wstrb`. A `s_wstrb` of 8'h0F writes only bytes 0 to 3 of the word.
- R8: `s_bvalid` rises in the cycle after the write acknowledge, with `s_bresp` equal to 2'b00. It stays high until `s_bready` is high on a clock edge.
- R9: Each AXI transaction produces exactly one acknowledged register-bus access, and `rb_stb` is low in the cycle after `rb_ack`.
- R10: When a read and a write are both offered in the same idle cycle, the read is accepted and the write is not (`s_awready` and `s_wready` are low). The write is accepted only after the read response has completed.
- R11: Synchronous active-high reset leaves the bridge idle, with `s_arready` high and `s_awready`, `s_wready`, `s_rvalid`, `s_bvalid` and `rb_stb` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| rb_stb | output | 1 | Register-bus access strobe |
| rb_we | output | 1 | Register-bus write flag |
| rb_addr | output | ADDR_W | Register-bus address |
| rb_wdata | output | DATA_W | Register-bus write data |
| rb_be | output | DATA_W/8 | Register-bus byte enables |
| rb_rdata | input | DATA_W | Register-bus read data |
| rb_ack | input | 1 | Register-bus acknowledge |

## Verification
Every one of sixteen words is first written and then read back, once for each register-bus wait count from zero to three. The count from acceptance to the response shows whether the zero-wait read path is taken and whether wait states delay the response by the correct amount. Full, low-half and high-half strobe masks rotate across the words, so a read-back that mixes old and new bytes shows whether byte enables reach the correct lanes. Runs with the response ready held low, plus one cycle that offers a read and a write together, cover response holding and read-first ordering.

// File: rtl/axrb_pkg.sv
package axrb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_ACC  = 3'd1,
      ST_RD_RESP = 3'd2,
      ST_WR_ACC  = 3'd3,
      ST_WR_RESP = 3'd4
   } axrb_state_e;

   localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axrb_req_latch.sv
// Captures the accepted address, write data and byte enables so the
// register bus is driven from internal state, not from the AXI inputs.
module axrb_req_latch #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 64,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ar_take,
   input  logic              aw_take,
   input  logic [ADDR_W-1:0] araddr,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   output logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_wdata,
   output logic [STRB_W-1:0] q_be
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q_addr  <= '0;
         q_wdata <= '0;
         q_be    <= '0;
      end else if (ar_take) begin
         q_addr  <= araddr;
         q_be    <= {STRB_W{1'b1}};
      end else if (aw_take) begin
         q_addr  <= awaddr;
         q_wdata <= wdata;
         q_be    <= wstrb;
      end
   end

endmodule

// File: rtl/axrb_ctrl.sv
// Transaction sequencer: one access per AXI transaction, read first.
module axrb_ctrl
   import axrb_pkg::*;
#(
   parameter bit READ_BYPASS = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        arvalid,
   input  logic        awvalid,
   input  logic        wvalid,
   input  logic        rready,
   input  logic        bready,
   input  logic        rb_ack,
   output logic        arready,
   output logic        awready,
   output logic        wready,
   output logic        ar_take,
   output logic        aw_take,
   output logic        rb_stb,
   output logic        rb_we,
   output logic        rvalid,
   output logic        rd_live,
   output logic        rd_cap,
   output logic        bvalid
);

   axrb_state_e st_q, st_d;
   logic        idle, rd_acc, wr_acc;
   logic        fast_rsp;

   assign idle    = (st_q == ST_IDLE);
   assign rd_acc  = (st_q == ST_RD_ACC);
   assign wr_acc  = (st_q == ST_WR_ACC);

   assign arready = idle;
   assign ar_take = idle & arvalid;
   assign awready = idle & ~arvalid & awvalid & wvalid;
   assign wready  = awready;
   assign aw_take = awready;

   assign rb_stb  = rd_acc | wr_acc;
   assign rb_we   = wr_acc;
   assign rd_cap  = rd_acc & rb_ack;
   assign bvalid  = (st_q == ST_WR_RESP);

   // Variant choice: answer in the access cycle, or always one cycle later.
   generate
      if (READ_BYPASS) begin : g_fast
         assign fast_rsp = rd_acc & rb_ack;
      end else begin : g_reg
         assign fast_rsp = 1'b0;
      end
   endgenerate

   assign rd_live = fast_rsp;
   assign rvalid  = fast_rsp | (st_q == ST_RD_RESP);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (arvalid)                st_d = ST_RD_ACC;
            else if (awvalid && wvalid) st_d = ST_WR_ACC;
         end
         ST_RD_ACC: begin
            if (rb_ack) st_d = (fast_rsp && rready) ? ST_IDLE : ST_RD_RESP;
         end
         ST_RD_RESP: if (rready) st_d = ST_IDLE;
         ST_WR_ACC:  if (rb_ack) st_d = ST_WR_RESP;
         ST_WR_RESP: if (bready) st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

endmodule

// File: rtl/axrb_rdata_hold.sv
// Holds read data once captured; optionally forwards live data on the
// fast response cycle.
module axrb_rdata_hold #(
   parameter int DATA_W      = 64,
   parameter bit READ_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap,
   input  logic              live,
   input  logic [DATA_W-1:0] rb_rdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (rst)      held_q <= '0;
      else if (cap) held_q <= rb_rdata;
   end

   generate
      if (READ_BYPASS) begin : g_mux
         assign rdata = live ? rb_rdata : held_q;
      end else begin : g_held
         assign rdata = held_q;
      end
   endgenerate

endmodule

// File: rtl/axil_regbus_bridge.sv
module axil_regbus_bridge
   import axrb_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 64,
   parameter bit READ_BYPASS = 1'b1,
   localparam int STRB_W     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   output logic              rb_stb,
   output logic              rb_we,
   output logic [ADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0] rb_wdata,
   output logic [STRB_W-1:0] rb_be,
   input  logic [DATA_W-1:0] rb_rdata,
   input  logic              rb_ack
);

   localparam int BYTE_BITS = $clog2(STRB_W);

   generate
      if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
         $error("axil_regbus_bridge: DATA_W must be 32 or 64");
      end
      if (ADDR_W <= BYTE_BITS) begin : g_bad_addr
         $error("axil_regbus_bridge: ADDR_W too small for the word size");
      end
   endgenerate

   logic ar_take, aw_take, rd_live, rd_cap;

   axrb_ctrl #(.READ_BYPASS(READ_BYPASS)) ctrl_i (
      .clk     (clk),
      .rst     (rst),
      .arvalid (s_arvalid),
      .awvalid (s_awvalid),
      .wvalid  (s_wvalid),
      .rready  (s_rready),
      .bready  (s_bready),
      .rb_ack  (rb_ack),
      .arready (s_arready),
      .awready (s_awready),
      .wready  (s_wready),
      .ar_take (ar_take),
      .aw_take (aw_take),
      .rb_stb  (rb_stb),
      .rb_we   (rb_we),
      .rvalid  (s_rvalid),
      .rd_live (rd_live),
      .rd_cap  (rd_cap),
      .bvalid  (s_bvalid)
   );

   axrb_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) latch_i (
      .clk     (clk),
      .rst     (rst),
      .ar_take (ar_take),
      .aw_take (aw_take),
      .araddr  (s_araddr),
      .awaddr  (s_awaddr),
      .wdata   (s_wdata),
      .wstrb   (s_wstrb),
      .q_addr  (rb_addr),
      .q_wdata (rb_wdata),
      .q_be    (rb_be)
   );

   axrb_rdata_hold #(.DATA_W(DATA_W), .READ_BYPASS(READ_BYPASS)) hold_i (
      .clk      (clk),
      .rst      (rst),
      .cap      (rd_cap),
      .live     (rd_live),
      .rb_rdata (rb_rdata),
      .rdata    (s_rdata)
   );

   assign s_rresp = RESP_OKAY;
   assign s_bresp = RESP_OKAY;

endmodule

// File: rtl/axrb_checker.sv
module axrb_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              s_arvalid,
   input logic              s_arready,
   input logic [DATA_W-1:0] s_rdata,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic              s_awready,
   input logic              s_wready,
   input logic [1:0]        s_bresp,
   input logic              s_bvalid,
   input logic              s_bready,
   input logic              rb_stb,
   input logic              rb_we,
   input logic [ADDR_W-1:0] rb_addr,
   input logic              rb_ack
);

   a_r2_no_rvalid_on_accept: assert property (@(posedge clk) disable iff (rst)
      (s_arvalid && s_arready) |-> !s_rvalid);

   a_r4_strobe_after_accept: assert property (@(posedge clk) disable iff (rst)
      (s_arvalid && s_arready) |=> (rb_stb && !rb_we));

   a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
      (rb_stb && !rb_ack) |=> (rb_stb && $stable(rb_addr)));

   a_r5_wait_no_rvalid: assert property (@(posedge clk) disable iff (rst)
      (rb_stb && !rb_we && !rb_ack) |-> !s_rvalid);

   a_r6_rvalid_hold: assert property (@(posedge clk) disable iff (rst)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

   a_r8_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
      (s_bvalid && !s_bready) |=> s_bvalid);

   a_r8_bresp_okay: assert property (@(posedge clk) disable iff (rst)
      s_bvalid |-> (s_bresp == 2'b00));

   a_r9_single_access: assert property (@(posedge clk) disable iff (rst)
      (rb_stb && rb_ack) |=> !rb_stb);

   a_r10_read_first: assert property (@(posedge clk) disable iff (rst)
      (s_arvalid && s_arready) |-> (!s_awready && !s_wready));

endmodule

bind axil_regbus_bridge axrb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .s_arvalid (s_arvalid),
   .s_arready (s_arready),
   .s_rdata   (s_rdata),
   .s_rvalid  (s_rvalid),
   .s_rready  (s_rready),
   .s_awready (s_awready),
   .s_wready  (s_wready),
   .s_bresp   (s_bresp),
   .s_bvalid  (s_bvalid),
   .s_bready  (s_bready),
   .rb_stb    (rb_stb),
   .rb_we     (rb_we),
   .rb_addr   (rb_addr),
   .rb_ack    (rb_ack)
);

// File: tb/axil_regbus_bridge_tb_top.sv
`timescale 1ns/1ps
module axil_regbus_bridge_tb_top;

   localparam int AW = 16;
   localparam int DW = 64;
   localparam int SW = DW / 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] araddr = '0, awaddr = '0;
   logic          arvalid = 1'b0, awvalid = 1'b0, wvalid = 1'b0;
   logic          rready = 1'b0, bready = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [SW-1:0] wstrb = '0;
   logic          arready, rvalid, awready, wready, bvalid;
   logic [DW-1:0] rdata;
   logic [1:0]    rresp, bresp;
   logic          rb_stb, rb_we, rb_ack;
   logic [AW-1:0] rb_addr;
   logic [DW-1:0] rb_wdata, rb_rdata;
   logic [SW-1:0] rb_be;

   int vec_cnt = 0;
   int bad_cnt = 0;
   int slave_waits = 0;
   int wcnt = 0;
   int acc_cnt = 0;
   logic [DW-1:0] smem [16];
   logic [DW-1:0] emem [16];

   always #10 clk = ~clk;

   axil_regbus_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst(rst),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .rb_stb(rb_stb), .rb_we(rb_we), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
      .rb_be(rb_be), .rb_rdata(rb_rdata), .rb_ack(rb_ack)
   );

   // Register-bus slave model with a programmable number of wait states.
   assign rb_ack   = rb_stb && (wcnt == slave_waits);
   assign rb_rdata = smem[rb_addr[6:3]];

   always @(posedge clk) begin
      if (rst) wcnt <= 0;
      else if (rb_stb && !rb_ack) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (!rst && rb_stb && rb_ack) begin
         acc_cnt <= acc_cnt + 1;
         if (rb_we)
            for (int b = 0; b < SW; b++)
               if (rb_be[b]) smem[rb_addr[6:3]][b*8 +: 8] <= rb_wdata[b*8 +: 8];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      vec_cnt++;
      if (!ok) begin
         bad_cnt++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [SW-1:0] s, input int waits, input bit hold);
      int n;
      int acc0;
      slave_waits = waits;
      @(negedge clk);
      awaddr = a; awvalid = 1'b1; wdata = d; wstrb = s; wvalid = 1'b1;
      #1 chk(awready && wready, "R7 write ready", {62'd0, awready, wready}, 64'd3);
      acc0 = acc_cnt;
      @(negedge clk);
      awvalid = 1'b0; wvalid = 1'b0; awaddr = ~a; wdata = ~d; wstrb = ~s;
      #1 chk(rb_stb && rb_we, "R7 write strobe", {62'd0, rb_stb, rb_we}, 64'd3);
      chk(rb_addr == a && rb_wdata == d, "R3 write latch", rb_wdata, d);
      chk(rb_be == s, "R7 byte enables", {56'd0, rb_be}, {56'd0, s});
      n = 0;
      while (!bvalid && n < 50) begin @(negedge clk); #1; n++; end
      chk(n == waits + 1, "R8 bvalid timing", 64'(n), 64'(waits + 1));
      chk(bresp == 2'b00, "R8 bresp okay", {62'd0, bresp}, 64'd0);
      for (int b = 0; b < SW; b++)
         if (s[b]) emem[a[6:3]][b*8 +: 8] = d[b*8 +: 8];
      if (hold) begin
         repeat (2) @(negedge clk);
         #1 chk(bvalid, "R8 bvalid held", {63'd0, bvalid}, 64'd1);
      end
      bready = 1'b1;
      @(negedge clk);
      #1 chk(!bvalid, "R8 bvalid drop", {63'd0, bvalid}, 64'd0);
      bready = 1'b0;
      chk(acc_cnt == acc0 + 1, "R9 one write access", 64'(acc_cnt), 64'(acc0 + 1));
   endtask

   task automatic do_read(input logic [AW-1:0] a, input int waits, input bit hold);
      int n;
      int acc0;
      logic [DW-1:0] d;
      slave_waits = waits;
      @(negedge clk);
      rready = !hold; araddr = a; arvalid = 1'b1;
      #1 chk(arready, "R1 arready idle", {63'd0, arready}, 64'd1);
      chk(!rvalid, "R2 no rvalid at accept", {63'd0, rvalid}, 64'd0);
      acc0 = acc_cnt;
      @(negedge clk);
      arvalid = 1'b0; araddr = ~a;
      #1 chk(rb_stb && !rb_we, "R4 read strobe", {62'd0, rb_stb, rb_we}, 64'd2);
      chk(rb_addr == a, "R3 read addr latch", 64'(rb_addr), 64'(a));
      n = 0;
      while (!rvalid && n < 50) begin @(negedge clk); #1; n++; end
      chk(n == waits, "R5 rvalid after waits", 64'(n), 64'(waits));
      chk(rdata == emem[a[6:3]], "R4 read data", rdata, emem[a[6:3]]);
      chk(rresp == 2'b00, "R4 rresp okay", {62'd0, rresp}, 64'd0);
      if (hold) begin
         d = rdata;
         repeat (2) @(negedge clk);
         #1 chk(rvalid && rdata == d, "R6 response held", rdata, d);
         rready = 1'b1;
      end
      @(negedge clk);
      #1 chk(!rvalid && arready, "R6 back to idle", {62'd0, rvalid, arready}, 64'd1);
      rready = 1'b0;
      chk(acc_cnt == acc0 + 1, "R9 one read access", 64'(acc_cnt), 64'(acc0 + 1));
   endtask

   initial begin
      int n;
      logic [SW-1:0] s;
      for (int i = 0; i < 16; i++) begin
         smem[i] = 64'h1111_0000_0000_0000 * i + 64'(i);
         emem[i] = 64'h1111_0000_0000_0000 * i + 64'(i);
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1 chk(arready && !awready && !wready && !rvalid && !bvalid && !rb_stb,
             "R11 reset state",
             {58'd0, arready, awready, wready, rvalid, bvalid, rb_stb}, 64'h20);

      for (int w = 0; w < 4; w++)
         for (int a = 0; a < 16; a++) begin
            s = (a % 3 == 0) ? 8'hFF : (a % 3 == 1) ? 8'h0F : 8'hF0;
            do_write(AW'(a * 8), {32'hC0DE_0000 + 32'(w), 32'hA500_0000 + 32'(a)},
                     s, w, (a == 5));
            do_read(AW'(a * 8), w, (a == 7));
         end

      // R10: read and write offered together; read goes first.
      slave_waits = 1;
      @(negedge clk);
      araddr = 16'h0010; arvalid = 1'b1; rready = 1'b1;
      awaddr = 16'h0018; awvalid = 1'b1; wdata = 64'h0123_4567_89AB_CDEF;
      wstrb = 8'hFF; wvalid = 1'b1;
      #1 chk(arready && !awready && !wready, "R10 read wins",
             {61'd0, arready, awready, wready}, 64'd4);
      @(negedge clk);
      arvalid = 1'b0;
      #1 chk(!awready, "R10 write waits", {63'd0, awready}, 64'd0);
      n = 0;
      while (!rvalid && n < 50) begin @(negedge clk); #1; n++; end
      chk(rdata == emem[2], "R10 read data", rdata, emem[2]);
      @(negedge clk);
      #1 chk(awready && wready, "R10 write after read", {62'd0, awready, wready}, 64'd3);
      rready = 1'b0;
      @(negedge clk);
      awvalid = 1'b0; wvalid = 1'b0;
      #1 chk(rb_stb && rb_we && rb_addr == 16'h0018, "R10 write access",
             64'(rb_addr), 64'h18);
      emem[3] = 64'h0123_4567_89AB_CDEF;
      n = 0;
      while (!bvalid && n < 50) begin @(negedge clk); #1; n++; end
      bready = 1'b1;
      @(negedge clk);
      bready = 1'b0;
      do_read(16'h0018, 0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad_cnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   end

endmodule